// File: doc/BRIEF.md
# Token-Chained Sparse Channel Readout

This block unloads one chip's digitized channels onto a byte-wide bus that many chips share. The chips form a chain and pass an active-low token along it. A chip begins sending when its upstream token input falls. After its last byte it pulls its downstream token output low, and the next chip in the chain takes over. A digitizer writes the channel values into a block-RAM store through a simple write port. Each value is compared with the threshold as it is written, and the result is kept as a hit flag.

Each word is sent in two halves. The address half carries the chip ID or a channel number, and the value half carries the status or a channel value; `addr_phase_o` marks which half is on the bus. A readout sends the chip ID, then a status byte holding the pipeline cell number, then a channel-number and value pair for each selected channel. Three selection modes exist: threshold only, threshold plus adjacent channels, and read-all. A channel mask removes channels in every mode.

Top module: `rdo_token_readout`

## Requirements
- R1: After reset, `bus_o` is 0, `bus_oe_o` is 0 and `bn_n_o` is 1.
- R2: A low `tok_n_i` is accepted only at a clock edge where `addr_phase_o` is 0. The cycle after acceptance shows `bus_oe_o`=1, `addr_phase_o`=1 and `bus_o` = chip ID zero-extended to 8 bits. `addr_phase_o` then alternates every cycle.
- R3: The byte after the chip ID is the status, `{2'b00, cell}`. When `cfg_rev_cell` is 1, the 6 cell bits are sent bit-reversed (cell 3 is sent as 0x30).
- R4: Each selected channel takes two consecutive bytes: its number (`addr_phase_o`=1), then its stored 8-bit value (`addr_phase_o`=0). Selected channels are sent in ascending order.
- R5: A channel is a hit when it is unmasked and the value written to it is greater than or equal to `cfg_thresh` at write time. In plain mode, only hits are sent.
- R6: With `cfg_read_nbr`=1, an unmasked channel is also sent when channel index-1 or index+1 is a hit. Indices outside 0..127 do not exist.
- R7: With `cfg_read_all`=1, every unmasked channel is sent, whatever its value.
- R8: A masked channel is never sent in any mode, and its value never makes a neighbour selected.
- R9: The cycle after the last byte, `bus_oe_o` drops and `bn_n_o` goes low on a chip that is not last. `bn_n_o` stays low until `tok_n_i` is high, then returns to 1.
- R10: With `cfg_last`=1, `bn_n_o` stays 1 at the end of a readout.
- R11: When `abort_i` is 1 at an edge, the block is idle from the next cycle: `bus_oe_o`=0, `bus_o`=0, `bn_n_o`=1.
- R12: With no channel selected, a readout is only the chip ID and the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chip_id | input | 7 | Chip identifier |
| cfg_thresh | input | 8 | Hit threshold |
| cfg_mask | input | 128 | 1 excludes the channel |
| cfg_read_all | input | 1 | Send all unmasked channels |
| cfg_read_nbr | input | 1 | Also send channels adjacent to a hit |
| cfg_rev_cell | input | 1 | Bit-reverse the cell number in the status |
| cfg_last | input | 1 | Chip ends the chain |
| cell_id | input | 6 | Pipeline cell number |
| wr_en | input | 1 | Channel value write strobe |
| wr_ch | input | 7 | Channel being written |
| wr_val | input | 8 | Digitized value |
| tok_n_i | input | 1 | Upstream token, active low |
| abort_i | input | 1 | Abandon readout |
| bus_o | output | 8 | Readout byte |
| bus_oe_o | output | 1 | Bus drive enable |
| addr_phase_o | output | 1 | 1: ID or channel-number half, 0: status or value half |
| bn_n_o | output | 1 | Downstream token, active low |

## Verification
The assertions assume that the configuration and the channel values stay fixed while a readout runs. They also assume that the upstream token stays low until the chip has passed it on or been aborted. The stimulus writes all values and sets every mode before it lowers the token. It raises the token only after `bn_n_o` has fallen, or in the same cycle as the abort pulse. The start half-phase is left to the design, so acceptance must align itself to it.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_CHAN,
    ST_TAIL,
    ST_PASS
  } rdo_state_e;
endpackage

// File: rtl/rdo_chanmem.sv
module rdo_chanmem #(
  parameter int NCH = 128,
  parameter int DW  = 8,
  localparam int AW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rdo_select.sv
module rdo_select #(
  parameter int NCH = 128
) (
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] mask,
  input  logic           read_all,
  input  logic           read_nbr,
  output logic [NCH-1:0] sel
);
  logic [NCH-1:0] live;
  assign live = hit & ~mask;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic below, above;
    if (g > 0) begin : g_lo
      assign below = live[g-1];
    end else begin : g_lo0
      assign below = 1'b0;
    end
    if (g < NCH-1) begin : g_hi
      assign above = live[g+1];
    end else begin : g_hi0
      assign above = 1'b0;
    end
    assign sel[g] = ~mask[g] & (read_all | live[g] | (read_nbr & (below | above)));
  end
endmodule

// File: rtl/rdo_scan.sv
module rdo_scan #(
  parameter int NCH = 128,
  localparam int AW = $clog2(NCH),
  localparam int SW = AW + 1
) (
  input  logic [NCH-1:0] sel,
  input  logic [SW-1:0]  start,
  output logic           found,
  output logic [AW-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH-1; i >= 0; i--) begin
      if (sel[i] && (SW'(i) >= start)) begin
        found = 1'b1;
        idx   = AW'(i);
      end
    end
  end
endmodule

// File: rtl/rdo_token_readout.sv
module rdo_token_readout
  import rdo_pkg::*;
#(
  parameter int NCH = 128,
  parameter int DW  = 8,
  parameter int IDW = 7,
  parameter int CW  = 6,
  localparam int AW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IDW-1:0] cfg_chip_id,
  input  logic [DW-1:0]  cfg_thresh,
  input  logic [NCH-1:0] cfg_mask,
  input  logic           cfg_read_all,
  input  logic           cfg_read_nbr,
  input  logic           cfg_rev_cell,
  input  logic           cfg_last,
  input  logic [CW-1:0]  cell_id,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_ch,
  input  logic [DW-1:0]  wr_val,
  input  logic           tok_n_i,
  input  logic           abort_i,
  output logic [DW-1:0]  bus_o,
  output logic           bus_oe_o,
  output logic           addr_phase_o,
  output logic           bn_n_o
);
  rdo_state_e     st;
  logic           ph;
  logic           any_q;
  logic [AW-1:0]  cur;
  logic [NCH-1:0] hit;
  logic [NCH-1:0] sel;
  logic [DW-1:0]  rd_q;
  logic           f0_found, fn_found;
  logic [AW-1:0]  f0_idx, fn_idx;
  logic [CW-1:0]  cell_fmt;

  // hit flags are evaluated against the threshold at write time
  always_ff @(posedge clk) begin
    if (rst) hit <= '0;
    else if (wr_en) hit[wr_ch] <= (wr_val >= cfg_thresh);
  end

  rdo_chanmem #(.NCH(NCH), .DW(DW)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_ch), .wdata(wr_val),
    .raddr(cur), .rdata(rd_q)
  );

  rdo_select #(.NCH(NCH)) u_sel (
    .hit(hit), .mask(cfg_mask), .read_all(cfg_read_all),
    .read_nbr(cfg_read_nbr), .sel(sel)
  );

  rdo_scan #(.NCH(NCH)) u_first (
    .sel(sel), .start('0), .found(f0_found), .idx(f0_idx)
  );

  rdo_scan #(.NCH(NCH)) u_next (
    .sel(sel), .start({1'b0, cur} + (AW+1)'(1)), .found(fn_found), .idx(fn_idx)
  );

  always_comb begin
    for (int b = 0; b < CW; b++)
      cell_fmt[b] = cfg_rev_cell ? cell_id[CW-1-b] : cell_id[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= 1'b0;
      any_q    <= 1'b0;
      cur      <= '0;
      bus_o    <= '0;
      bus_oe_o <= 1'b0;
      bn_n_o   <= 1'b1;
    end else begin
      ph <= ~ph;
      if (abort_i) begin
        st       <= ST_IDLE;
        bus_o    <= '0;
        bus_oe_o <= 1'b0;
        bn_n_o   <= 1'b1;
      end else begin
        unique case (st)
          ST_IDLE: if (!ph && !tok_n_i) begin
            st       <= ST_HDR;
            bus_oe_o <= 1'b1;
            bus_o    <= DW'(cfg_chip_id);
            cur      <= f0_idx;
            any_q    <= f0_found;
          end
          ST_HDR: begin
            bus_o <= DW'(cell_fmt);
            st    <= any_q ? ST_CHAN : ST_TAIL;
          end
          ST_CHAN: begin
            if (!ph) begin
              bus_o <= DW'(cur);
            end else begin
              bus_o <= rd_q;
              if (fn_found) cur <= fn_idx;
              else          st  <= ST_TAIL;
            end
          end
          ST_TAIL: begin
            bus_o    <= '0;
            bus_oe_o <= 1'b0;
            bn_n_o   <= cfg_last;
            st       <= ST_PASS;
          end
          ST_PASS: if (tok_n_i) begin
            bn_n_o <= 1'b1;
            st     <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign addr_phase_o = ph;

  assert_drive_holds_token_R9: assert property (@(posedge clk) disable iff (rst)
    bus_oe_o |-> bn_n_o);
  assert_pass_at_end_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(bn_n_o) |-> $fell(bus_oe_o));
  assert_last_keeps_token_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(bn_n_o) |-> !cfg_last);
  assert_start_on_token_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe_o) |-> ($past(!tok_n_i) && addr_phase_o));
  assert_abort_idles_R11: assert property (@(posedge clk) disable iff (rst)
    $past(abort_i) |-> (!bus_oe_o && bn_n_o));
  assert_ascending_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHAN && $past(st) == ST_CHAN && cur != $past(cur)) |-> (cur > $past(cur)));
  assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_o |-> (bus_o == '0));
endmodule

// File: tb/rdo_token_readout_bench.sv
module rdo_token_readout_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [6:0]   cfg_chip_id = 7'h55;
  logic [7:0]   cfg_thresh = 8'h40;
  logic [127:0] cfg_mask = '0;
  logic         cfg_read_all = 1'b0, cfg_read_nbr = 1'b0, cfg_rev_cell = 1'b0, cfg_last = 1'b0;
  logic [5:0]   cell_id = 6'd3;
  logic         wr_en = 1'b0;
  logic [6:0]   wr_ch = '0;
  logic [7:0]   wr_val = '0;
  logic         tok_n_i = 1'b1, abort_i = 1'b0;
  logic [7:0]   bus_o;
  logic         bus_oe_o, addr_phase_o, bn_n_o;

  int tests = 0, fails = 0;
  logic [7:0] bv [128];
  logic [7:0] eb [400];
  int en;
  logic [7:0] gb [400];
  logic       gp [400];

  always #2 clk = ~clk;

  rdo_token_readout u_rdo_token_readout (
    .clk(clk), .rst(rst), .cfg_chip_id(cfg_chip_id), .cfg_thresh(cfg_thresh),
    .cfg_mask(cfg_mask), .cfg_read_all(cfg_read_all), .cfg_read_nbr(cfg_read_nbr),
    .cfg_rev_cell(cfg_rev_cell), .cfg_last(cfg_last), .cell_id(cell_id),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_val(wr_val), .tok_n_i(tok_n_i),
    .abort_i(abort_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .addr_phase_o(addr_phase_o), .bn_n_o(bn_n_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_vals();
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_ch = 7'(i); wr_val = bv[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic build_exp();
    bit h [128];
    bit s;
    logic [5:0] c;
    for (int i = 0; i < 128; i++) h[i] = !cfg_mask[i] && (bv[i] >= cfg_thresh);
    for (int b = 0; b < 6; b++) c[b] = cfg_rev_cell ? cell_id[5-b] : cell_id[b];
    eb[0] = {1'b0, cfg_chip_id};
    eb[1] = {2'b00, c};
    en = 2;
    for (int i = 0; i < 128; i++) begin
      s = !cfg_mask[i] && (cfg_read_all || h[i] ||
          (cfg_read_nbr && ((i > 0 && h[i-1]) || (i < 127 && h[i+1]))));
      if (s) begin
        eb[en] = 8'(i); eb[en+1] = bv[i]; en += 2;
      end
    end
  endtask

  task automatic run_chk(input string tag);
    int n = 0;
    bit seen = 0;
    int bad = -1;
    int badph = -1;
    build_exp();
    tok_n_i = 1'b0;
    for (int c = 0; c < 1200; c++) begin
      @(negedge clk);
      if (bus_oe_o) begin
        if (n < 400) begin gb[n] = bus_o; gp[n] = addr_phase_o; end
        n++; seen = 1;
      end else if (seen) break;
    end
    chk(n == en, {tag, " R4 byte count"}, n, en);
    for (int k = 0; k < n && k < en && k < 400; k++) begin
      if (bad < 0 && gb[k] !== eb[k]) bad = k;
      if (badph < 0 && gp[k] !== ((k % 2) == 0)) badph = k;
    end
    if (bad >= 0) chk(0, {tag, " stream byte"}, int'(gb[bad]), int'(eb[bad]));
    else chk(1, tag, 0, 0);
    chk(n > 0 && gb[0] == {1'b0, cfg_chip_id}, "R2 chip id first", int'(gb[0]), int'({1'b0, cfg_chip_id}));
    chk(badph < 0, "R2 half-phase alternation", badph, -1);
    chk(n > 1 && gb[1] == eb[1], "R3 status byte", int'(gb[1]), int'(eb[1]));
    if (cfg_last) chk(bn_n_o == 1'b1, "R10 last chip keeps token", bn_n_o, 1);
    else          chk(bn_n_o == 1'b0, "R9 token passed", bn_n_o, 0);
    tok_n_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(bn_n_o == 1'b1 && !bus_oe_o, "R9 token released", bn_n_o, 1);
  endtask

  task automatic t_reset();
    chk(bus_o == 8'h00, "R1 bus", bus_o, 0);
    chk(bus_oe_o == 1'b0, "R1 oe", bus_oe_o, 0);
    chk(bn_n_o == 1'b1, "R1 bn", bn_n_o, 1);
  endtask

  task automatic t_threshold();
    // R5: equal value selected, one below not; R4 ascending order
    for (int i = 0; i < 128; i++) bv[i] = 8'(i % 16);
    bv[5] = 8'h40; bv[6] = 8'h3f; bv[40] = 8'hff; bv[90] = 8'h41; bv[127] = 8'h80;
    cfg_thresh = 8'h40;
    load_vals();
    run_chk("R5 threshold");
  endtask

  task automatic t_neighbours();
    // R6: edges 0 and 127, adjacent hits, masked hit gives no neighbours (R8)
    for (int i = 0; i < 128; i++) bv[i] = 8'h01;
    bv[0] = 8'h90; bv[60] = 8'h90; bv[61] = 8'h90; bv[127] = 8'h90; bv[100] = 8'h90;
    cfg_mask = '0; cfg_mask[100] = 1'b1; cfg_mask[59] = 1'b1;
    cfg_thresh = 8'h50; cfg_read_nbr = 1'b1;
    load_vals();
    run_chk("R6 neighbours");
    cfg_read_nbr = 1'b0; cfg_mask = '0;
  endtask

  task automatic t_read_all();
    // R7 with R8 mask, R3 reversed cell, R10 last chip
    for (int i = 0; i < 128; i++) bv[i] = 8'(i * 3);
    cfg_mask = '0; cfg_mask[0] = 1'b1; cfg_mask[64] = 1'b1; cfg_mask[127] = 1'b1;
    cfg_read_all = 1'b1; cfg_rev_cell = 1'b1; cfg_last = 1'b1; cell_id = 6'd3;
    load_vals();
    run_chk("R7 read-all R8 mask");
    cfg_read_all = 1'b0; cfg_rev_cell = 1'b0; cfg_last = 1'b0; cfg_mask = '0;
  endtask

  task automatic t_empty();
    // R12: nothing above threshold
    for (int i = 0; i < 128; i++) bv[i] = 8'h10;
    cfg_thresh = 8'hf0; cell_id = 6'd45;
    load_vals();
    run_chk("R12 empty");
  endtask

  task automatic t_abort();
    // R11: abort mid-readout
    for (int i = 0; i < 128; i++) bv[i] = 8'hff;
    cfg_thresh = 8'h01;
    load_vals();
    tok_n_i = 1'b0;
    for (int c = 0; c < 10 && !bus_oe_o; c++) @(negedge clk);
    repeat (5) @(negedge clk);
    abort_i = 1'b1; tok_n_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk(bus_oe_o == 1'b0, "R11 oe after abort", bus_oe_o, 0);
    chk(bus_o == 8'h00, "R11 bus after abort", bus_o, 0);
    chk(bn_n_o == 1'b1, "R11 bn after abort", bn_n_o, 1);
    repeat (4) @(negedge clk);
    chk(bus_oe_o == 1'b0, "R11 stays idle", bus_oe_o, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_neighbours();
    t_read_all();
    t_empty();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule